// File: doc/BRIEF.md
# Packet to bus transaction bridge

This block turns byte-wide request packets into accesses on a 32-bit memory-mapped master port, then answers each request with a response packet on a byte-wide streaming source. Each request opens with an eight-byte header that names an operation, a byte count and a start address. Write payload bytes follow the header. The bridge packs them into words and issues one word write at a time. A read fetches words and streams them back as bytes.

The bridge handles one request at a time. It does not buffer data in either direction. A stalled memory side holds the request stream still. A stalled response stream stops any new read from being issued. Write length comes from the end-of-packet marker on the request, not from the header count. Operation codes that the bridge does not recognise get a short acknowledgement and no bus access.

Top module: `pkt_bus_bridge`

## Requirements
- R1: A request header is 8 bytes. The byte with `in_sop` set is byte 0, the operation code. Byte 1 is ignored. Bytes 2 and 3 are the byte count, big-endian. Bytes 4 to 7 are the start address, big-endian. A non-sop byte that arrives while no header is open is dropped.
- R2: Code 0x04 writes incrementing words. Word i goes to start address + 4*i. Payload bytes pack into each word lowest lane first, so the first byte of a word lands in bits 7:0.
- R3: Code 0x00 writes every payload word to the start address itself.
- R4: The write payload ends at the beat with `in_eop`, whatever the header count says. A last word that is not full is padded with zero bytes before it is written. When the header's own last byte carries `in_eop`, nothing is written. After the last write, the response is 4 bytes: code OR 0x80, then 0x00, then the count of payload bytes accepted as 16 bits big-endian. `out_sop` marks the first byte and `out_eop` the last.
- R5: Code 0x14 with a non-zero count returns exactly that many bytes. Word j is read at start address + 4*j, and each word's bytes are sent bits 7:0 first. Unused lanes of the last word are discarded. `out_sop` marks the first byte and `out_eop` the last.
- R6: Code 0x10 reads every word from the start address and otherwise behaves as R5.
- R7: Code 0x7f, any code other than 0x00/0x04/0x10/0x14, and a read with count 0 cause no bus access. Each still receives the R4 four-byte response with count 0.
- R8: `in_ready` is low whenever `out_valid` is high. `mm_read` and `mm_write` are never high together.
- R9: While an access is pending and `mm_wait` is high, `in_ready` is low. A pending write also keeps `mm_write`, `mm_addr` and `mm_wdata` unchanged.
- R10: `mm_read` is low whenever `out_ready` is low. A response byte that is not accepted stays valid with unchanged data and markers.
- R11: After reset, `out_valid`, `mm_write` and `mm_read` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request byte valid |
| in_ready | output | 1 | Bridge accepts a request byte |
| in_data | input | 8 | Request byte |
| in_sop | input | 1 | First byte of a request |
| in_eop | input | 1 | Last byte of a request |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Downstream accepts a response byte |
| out_data | output | 8 | Response byte |
| out_sop | output | 1 | First byte of a response |
| out_eop | output | 1 | Last byte of a response |
| mm_addr | output | 32 | Access byte address |
| mm_write | output | 1 | Write request |
| mm_read | output | 1 | Read request |
| mm_wdata | output | 32 | Write word |
| mm_rdata | input | 32 | Read word, valid when a read is accepted |
| mm_wait | input | 1 | Slave stalls the pending access |

## Verification
The bench checks each of the following corner cases, and each has a typical failure:

- **Write payloads that end mid-word or disagree with the header count.** A bridge that trusted the count, or skipped zero padding, would write too many or too few words, or write stale upper lanes.
- **Reads whose count is not a multiple of four, in both address modes.** An unpacker with a wrong lane or end condition would send extra bytes, misplace the end marker, or step the address in fixed mode.
- **Empty writes, zero-count reads, the no-op code and an unknown code.** A bridge that mishandled these would issue a spurious access or never answer.
- **Random stalls on both `mm_wait` and `out_ready` throughout.** These expose a read issued into a stalled stream, or a request byte taken while the slave stalls.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
  typedef enum logic [1:0] {ST_HDR, ST_WDAT, ST_RDAT, ST_RESP} pbb_state_t;

  localparam logic [7:0] OP_WR_FIX = 8'h00;
  localparam logic [7:0] OP_WR_INC = 8'h04;
  localparam logic [7:0] OP_RD_FIX = 8'h10;
  localparam logic [7:0] OP_RD_INC = 8'h14;
  localparam logic [7:0] RESP_FLAG = 8'h80;
  localparam int SIZE_W     = 16;
  localparam int RESP_BYTES = 4;

  function automatic logic op_is_wr(input logic [7:0] c);
    return (c == OP_WR_FIX) || (c == OP_WR_INC);
  endfunction

  function automatic logic op_is_rd(input logic [7:0] c);
    return (c == OP_RD_FIX) || (c == OP_RD_INC);
  endfunction
endpackage

// File: rtl/pbb_hdr_capture.sv
module pbb_hdr_capture #(
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      take,
  input  logic [7:0]                byte_i,
  input  logic                      sop_i,
  input  logic                      eop_i,
  output logic                      done,
  output logic [7:0]                code_o,
  output logic [pbb_pkg::SIZE_W-1:0] size_o,
  output logic [ADDR_W-1:0]         addr_o
);
  localparam int HDR_LEN = 4 + ADDR_W / 8;
  localparam int IDX_W   = $clog2(HDR_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_LEN - 1);

  logic [IDX_W-1:0]          idx;
  logic                      active;
  logic [7:0]                code_q;
  logic [pbb_pkg::SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0]         addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      active <= 1'b0;
      code_q <= '0;
      size_q <= '0;
      addr_q <= '0;
    end else if (take) begin
      if (sop_i) begin
        code_q <= byte_i;
        idx    <= IDX_W'(1);
        active <= !eop_i;
      end else if (active) begin
        idx <= idx + 1'b1;
        if (idx == IDX_W'(2)) size_q[15:8] <= byte_i;
        if (idx == IDX_W'(3)) size_q[7:0]  <= byte_i;
        if (idx >= IDX_W'(4)) addr_q <= {addr_q[ADDR_W-9:0], byte_i};
        if (eop_i || idx == LAST_IDX) active <= 1'b0;
      end
    end
  end

  assign done   = take && !sop_i && active && (idx == LAST_IDX);
  assign code_o = code_q;
  assign size_o = size_q;
  assign addr_o = {addr_q[ADDR_W-9:0], byte_i};
endmodule

// File: rtl/pbb_wr_pack.sv
module pbb_wr_pack #(
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       byte_ok,
  input  logic [7:0]                 byte_i,
  input  logic                       last_i,
  input  logic                       issued,
  output logic [DATA_W-1:0]          word_o,
  output logic                       full_o,
  output logic                       last_o,
  output logic [pbb_pkg::SIZE_W-1:0] cnt_o
);
  localparam int BPW    = DATA_W / 8;
  localparam int LANE_W = (BPW > 1) ? $clog2(BPW) : 1;
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(BPW - 1);

  logic [LANE_W-1:0] lane;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      word_o <= '0;
      lane   <= '0;
      full_o <= 1'b0;
      last_o <= 1'b0;
      cnt_o  <= '0;
    end else begin
      if (issued) begin
        full_o <= 1'b0;
        word_o <= '0;
        lane   <= '0;
      end
      if (byte_ok) begin
        word_o[{lane, 3'b000} +: 8] <= byte_i;
        lane  <= lane + 1'b1;
        cnt_o <= cnt_o + 1'b1;
        if (lane == TOP_LANE || last_i) full_o <= 1'b1;
        if (last_i) last_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbb_rd_unpack.sv
module pbb_rd_unpack #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] word_i,
  input  logic              pop,
  input  logic              pop_end,
  output logic              have_o,
  output logic [7:0]        byte_o,
  output logic              top_lane_o
);
  localparam int BPW    = DATA_W / 8;
  localparam int LANE_W = (BPW > 1) ? $clog2(BPW) : 1;
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(BPW - 1);

  logic [DATA_W-1:0] word_q;
  logic [LANE_W-1:0] lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      lane   <= '0;
      have_o <= 1'b0;
    end else if (load) begin
      word_q <= word_i;
      lane   <= '0;
      have_o <= 1'b1;
    end else if (pop) begin
      lane <= lane + 1'b1;
      if (pop_end) have_o <= 1'b0;
    end
  end

  assign byte_o     = word_q[{lane, 3'b000} +: 8];
  assign top_lane_o = (lane == TOP_LANE);
endmodule

// File: rtl/pkt_bus_bridge.sv
module pkt_bus_bridge #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [ADDR_W-1:0] mm_addr,
  output logic              mm_write,
  output logic              mm_read,
  output logic [DATA_W-1:0] mm_wdata,
  input  logic [DATA_W-1:0] mm_rdata,
  input  logic              mm_wait
);
  import pbb_pkg::*;

  localparam int BPW    = DATA_W / 8;
  localparam int RIDX_W = $clog2(RESP_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BPW);
  localparam logic [RIDX_W-1:0] RIDX_LAST = RIDX_W'(RESP_BYTES - 1);

  pbb_state_t          st;
  logic [7:0]          code_r;
  logic [ADDR_W-1:0]   addr_r;
  logic                inc_r;
  logic [SIZE_W-1:0]   remain;
  logic                rd_first;
  logic [RIDX_W-1:0]   ridx;

  logic                take, hdr_take, hdr_done;
  logic [7:0]          hc_code;
  logic [SIZE_W-1:0]   hc_size;
  logic [ADDR_W-1:0]   hc_addr;
  logic                pk_full, pk_last, wr_done;
  logic [DATA_W-1:0]   pk_word;
  logic [SIZE_W-1:0]   pk_cnt;
  logic                rd_load, uh_have, uh_top, pop, pop_end;
  logic [7:0]          uh_byte;

  assign in_ready = (st == ST_HDR) || (st == ST_WDAT && !pk_full);
  assign take     = in_valid && in_ready;
  assign hdr_take = take && (st == ST_HDR);

  pbb_hdr_capture #(.ADDR_W(ADDR_W)) u_hdr (
    .clk(clk), .rst(rst), .take(hdr_take), .byte_i(in_data),
    .sop_i(in_sop), .eop_i(in_eop), .done(hdr_done),
    .code_o(hc_code), .size_o(hc_size), .addr_o(hc_addr)
  );

  assign wr_done = mm_write && !mm_wait;

  pbb_wr_pack #(.DATA_W(DATA_W)) u_pack (
    .clk(clk), .rst(rst), .clear(hdr_done),
    .byte_ok(take && st == ST_WDAT), .byte_i(in_data), .last_i(in_eop),
    .issued(wr_done), .word_o(pk_word), .full_o(pk_full),
    .last_o(pk_last), .cnt_o(pk_cnt)
  );

  assign mm_write = pk_full;
  assign mm_wdata = pk_word;
  assign mm_addr  = addr_r;
  assign mm_read  = (st == ST_RDAT) && !uh_have && out_ready;
  assign rd_load  = mm_read && !mm_wait;

  pbb_rd_unpack #(.DATA_W(DATA_W)) u_unpack (
    .clk(clk), .rst(rst), .load(rd_load), .word_i(mm_rdata),
    .pop(pop && st == ST_RDAT), .pop_end(pop_end),
    .have_o(uh_have), .byte_o(uh_byte), .top_lane_o(uh_top)
  );

  assign pop_end = uh_top || (remain == SIZE_W'(1));

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    case (st)
      ST_RESP: begin
        out_valid = 1'b1;
        out_sop   = (ridx == '0);
        out_eop   = (ridx == RIDX_LAST);
        case (ridx)
          2'd0:    out_data = code_r | RESP_FLAG;
          2'd1:    out_data = 8'h00;
          2'd2:    out_data = pk_cnt[15:8];
          default: out_data = pk_cnt[7:0];
        endcase
      end
      ST_RDAT: begin
        out_valid = uh_have;
        out_data  = uh_byte;
        out_sop   = rd_first;
        out_eop   = (remain == SIZE_W'(1));
      end
      default: ;
    endcase
  end

  assign pop = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_HDR;
      code_r   <= '0;
      addr_r   <= '0;
      inc_r    <= 1'b0;
      remain   <= '0;
      rd_first <= 1'b0;
      ridx     <= '0;
    end else begin
      case (st)
        ST_HDR: if (hdr_done) begin
          code_r <= hc_code;
          addr_r <= hc_addr;
          inc_r  <= hc_code[2];
          ridx   <= '0;
          if (op_is_wr(hc_code)) begin
            st <= in_eop ? ST_RESP : ST_WDAT;
          end else if (op_is_rd(hc_code) && hc_size != '0) begin
            st       <= ST_RDAT;
            remain   <= hc_size;
            rd_first <= 1'b1;
          end else begin
            st <= ST_RESP;
          end
        end
        ST_WDAT: if (wr_done) begin
          if (pk_last) st <= ST_RESP;
          else if (inc_r) addr_r <= addr_r + STEP;
        end
        ST_RDAT: if (pop) begin
          remain   <= remain - 1'b1;
          rd_first <= 1'b0;
          if (pop_end && inc_r) addr_r <= addr_r + STEP;
          if (remain == SIZE_W'(1)) st <= ST_HDR;
        end
        ST_RESP: if (pop) begin
          ridx <= ridx + 1'b1;
          if (ridx == RIDX_LAST) st <= ST_HDR;
        end
        default: st <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/pbb_checker.sv
module pbb_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_data,
  input logic              in_sop,
  input logic              in_eop,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              out_sop,
  input logic              out_eop,
  input logic [ADDR_W-1:0] mm_addr,
  input logic              mm_write,
  input logic              mm_read,
  input logic [DATA_W-1:0] mm_wdata,
  input logic [DATA_W-1:0] mm_rdata,
  input logic              mm_wait
);
  p_sink_shut_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_one_access_r8: assert property (@(posedge clk) disable iff (rst)
    !(mm_read && mm_write));

  p_wait_stall_r9: assert property (@(posedge clk) disable iff (rst)
    ((mm_write || mm_read) && mm_wait) |-> !in_ready);

  p_write_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mm_write && mm_wait) |=> (mm_write && $stable(mm_addr) && $stable(mm_wdata)));

  p_read_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !out_ready |-> !mm_read);

  p_src_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_sop) && $stable(out_eop)));
endmodule

bind pkt_bus_bridge pbb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pkt_bus_bridge_tb.sv
`timescale 1ns/1ps
module pkt_bus_bridge_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0]  in_data = 0;
  logic        in_ready;
  logic        out_valid, out_sop, out_eop;
  logic        out_ready = 1;
  logic [7:0]  out_data;
  logic [31:0] mm_addr, mm_wdata, mm_rdata;
  logic        mm_write, mm_read;
  logic        mm_wait = 0;

  pkt_bus_bridge u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .mm_addr(mm_addr),
    .mm_write(mm_write), .mm_read(mm_read), .mm_wdata(mm_wdata),
    .mm_rdata(mm_rdata), .mm_wait(mm_wait)
  );

  logic [31:0] mem [64];
  assign mm_rdata = mem[mm_addr[7:2]];

  int total = 0, bad = 0;
  int viol_r8 = 0, viol_r9 = 0, viol_r10 = 0;
  int rd_cnt = 0;
  logic [31:0] wl_a[$], wl_d[$];
  logic [9:0]  rxq[$];
  logic        got_eop = 0;
  bit          rand_bp = 0;

  logic        s_out_hs = 0, s_out_sop = 0, s_out_eop = 0, s_wr_hs = 0, s_rd_hs = 0;
  logic [7:0]  s_out_data = 0;
  logic [31:0] s_addr = 0, s_wdata = 0;

  // random backpressure on both sides
  always @(negedge clk) begin
    if (rand_bp) begin
      out_ready <= ($urandom % 4) != 0;
      mm_wait   <= ($urandom % 3) == 0;
    end else begin
      out_ready <= 1'b1;
      mm_wait   <= 1'b0;
    end
  end

  // snapshot settled port values between edges
  always @(negedge clk) begin
    #1;
    s_out_hs   = out_valid && out_ready;
    s_out_data = out_data;
    s_out_sop  = out_sop;
    s_out_eop  = out_eop;
    s_wr_hs    = mm_write && !mm_wait;
    s_rd_hs    = mm_read && !mm_wait;
    s_addr     = mm_addr;
    s_wdata    = mm_wdata;
    if (!rst) begin
      if (out_valid && in_ready) viol_r8++;
      if (mm_read && mm_write) viol_r8++;
      if ((mm_write || mm_read) && mm_wait && in_ready) viol_r9++;
      if (mm_read && !out_ready) viol_r10++;
    end
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (s_out_hs) begin
        rxq.push_back({s_out_sop, s_out_eop, s_out_data});
        if (s_out_eop) got_eop = 1'b1;
      end
      if (s_wr_hs) begin
        wl_a.push_back(s_addr);
        wl_d.push_back(s_wdata);
        mem[s_addr[7:2]] <= s_wdata;
      end
      if (s_rd_hs) rd_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_addr(input logic [31:0] base, input bit inc, input int i);
    return inc ? base + 32'(4 * i) : base;
  endfunction

  function automatic logic [31:0] pack_word(input logic [7:0] d[$], input int w);
    logic [31:0] r = '0;
    for (int l = 0; l < 4; l++)
      if (4 * w + l < d.size()) r[8*l +: 8] = d[4*w+l];
    return r;
  endfunction

  task automatic put_byte(input logic [7:0] b, input logic sop, input logic eop);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_sop = sop; in_eop = eop;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // R1 header layout: code, reserved, size BE, address BE
  task automatic run_txn(input logic [7:0] code, input int size, input logic [31:0] addr,
                         input int ndata, input string req);
    logic [7:0]  d[$];
    logic [7:0]  h[8];
    logic [9:0]  exp[$];
    logic [31:0] ea[$], ed[$];
    bit is_wr, is_rd, inc;
    int exp_rd, cnt;
    is_wr = (code == 8'h00) || (code == 8'h04);
    is_rd = ((code == 8'h10) || (code == 8'h14)) && size != 0;
    inc   = code[2];
    if (!is_wr) ndata = 0;
    for (int i = 0; i < ndata; i++) d.push_back(8'($urandom));
    exp_rd = 0;
    if (is_wr)
      for (int w = 0; w < (ndata + 3) / 4; w++) begin
        ea.push_back(word_addr(addr, inc, w));
        ed.push_back(pack_word(d, w));
      end
    if (is_rd) begin
      exp_rd = (size + 3) / 4;
      for (int k = 0; k < size; k++) begin
        logic [31:0] a, m;
        a = word_addr(addr, inc, k / 4);
        m = mem[a[7:2]];
        exp.push_back({k == 0, k == size - 1, m[8*(k%4) +: 8]});
      end
    end else begin
      cnt = is_wr ? ndata : 0;
      exp.push_back({2'b10, code | 8'h80});
      exp.push_back({2'b00, 8'h00});
      exp.push_back({2'b00, 8'(cnt >> 8)});
      exp.push_back({2'b01, 8'(cnt)});
    end
    wl_a.delete(); wl_d.delete(); rxq.delete(); rd_cnt = 0; got_eop = 0;
    h[0] = code; h[1] = 8'($urandom); h[2] = 8'(size >> 8); h[3] = 8'(size);
    h[4] = addr[31:24]; h[5] = addr[23:16]; h[6] = addr[15:8]; h[7] = addr[7:0];
    for (int i = 0; i < 8; i++) put_byte(h[i], i == 0, (i == 7) && (ndata == 0));
    for (int i = 0; i < ndata; i++) put_byte(d[i], 1'b0, i == ndata - 1);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    while (!got_eop) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(wl_a.size() == ea.size(), req, "write count", wl_a.size(), ea.size());
    for (int i = 0; i < ea.size() && i < wl_a.size(); i++) begin
      chk(wl_a[i] == ea[i], req, "write addr", wl_a[i], ea[i]);
      chk(wl_d[i] == ed[i], req, "write data", wl_d[i], ed[i]);
    end
    chk(rd_cnt == exp_rd, req, "read count", rd_cnt, exp_rd);
    chk(rxq.size() == exp.size(), req, "resp length", rxq.size(), exp.size());
    for (int i = 0; i < exp.size() && i < rxq.size(); i++)
      chk(rxq[i] == exp[i], req, "resp byte {sop,eop,data}", rxq[i], exp[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(!out_valid, "R11", "out_valid after reset", out_valid, 0);
    chk(!mm_write && !mm_read, "R11", "access after reset", {mm_write, mm_read}, 0);
    chk(in_ready, "R11", "in_ready after reset", in_ready, 1);

    // directed, no backpressure
    run_txn(8'h04, 8, 32'h0000_0010, 8, "R2");
    run_txn(8'h00, 12, 32'h0000_0020, 5, "R3 R4");
    run_txn(8'h04, 3, 32'h0000_0040, 0, "R4 empty");
    run_txn(8'h14, 7, 32'h0000_0010, 0, "R5");
    run_txn(8'h10, 9, 32'h0000_0020, 0, "R6");
    run_txn(8'h7f, 4, 32'h0000_0000, 0, "R7 noop");
    run_txn(8'h33, 4, 32'h0000_0000, 0, "R7 unknown");
    run_txn(8'h14, 0, 32'h0000_0000, 0, "R7 zero read");

    // stray byte without sop is dropped (R1)
    put_byte(8'h14, 1'b0, 1'b1);
    @(negedge clk); in_valid = 1'b0; in_eop = 1'b0;
    repeat (5) @(negedge clk);
    chk(!out_valid && rd_cnt == 0, "R1", "stray byte ignored", out_valid, 0);

    rand_bp = 1;
    run_txn(8'h04, 2, 32'h0000_0080, 11, "R4 R9");
    run_txn(8'h14, 13, 32'h0000_0080, 0, "R5 R10");
    for (int t = 0; t < 40; t++) begin
      logic [7:0] c;
      int sel;
      sel = $urandom % 6;
      case (sel)
        0: c = 8'h00; 1: c = 8'h04; 2: c = 8'h10; 3: c = 8'h14; 4: c = 8'h7f;
        default: c = 8'($urandom);
      endcase
      run_txn(c, $urandom % 20, {24'h0, 8'($urandom) & 8'hfc}, $urandom % 20, "R2-R7 mix");
    end
    rand_bp = 0;
    chk(viol_r8 == 0, "R8", "sink open while responding", viol_r8, 0);
    chk(viol_r9 == 0, "R9", "sink open during stall", viol_r9, 0);
    chk(viol_r10 == 0, "R10", "read while source stalled", viol_r10, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule